// File: doc/BRIEF.md
# Address-Sliced Multi-Queue Write Channel

This block sits between an upstream write bus and a downstream memory controller. Every write the upstream side offers carries an address and a data word. The write is placed into one of several internal queues, and the queue is chosen from a small slice of the address. The default build has four queues, each four entries deep. The channel tells the upstream side, combinationally, whether the queue that the currently offered address maps to has room. Upstream keeps its request on the port until that happens.

On the downstream side, a rotating selector chooses one non-empty queue at a time. The head entry of that queue moves into a single outbound request register. That register holds the request until the memory controller acknowledges it. No other request leaves the channel while one is outstanding. After each acknowledged transfer, the rotation restarts its search at the queue after the one just served. Busy and idle queues therefore share the memory port fairly.

Top module: `wq_write_channel`

## Requirements
- R1: The queue index of a write is the address field `in_addr[OFFSET +: log2(NQ)]`; with the defaults (OFFSET=2, NQ=4) that is `in_addr[3:2]`. An accepted write enters exactly that queue.
- R2: `in_ready` is high exactly when the queue selected by the present `in_addr` holds fewer than DEPTH entries. A write offered while `in_ready` is low is not taken and never appears downstream.
- R3: Writes leave any single queue in the order they were accepted, with address and data unchanged.
- R4: When the channel issues, it serves the first non-empty queue found by searching upward, with wrap-around, from the queue after the last one whose request was acknowledged. The search starts at queue 0 after reset. The search position moves only on an acknowledged transfer.
- R5: When no request is outstanding, an entry accepted at clock edge k raises `out_req` at edge k+1, unless another queue is served first.
- R6: While `out_req` is high and `out_ack` is low, `out_req`, `out_addr` and `out_data` hold their values.
- R7: A request is complete at the edge where `out_req` and `out_ack` are both high. `out_req` is low during the following cycle.
- R8: `out_ack` has no effect while `out_req` is low: it neither completes a transfer nor moves the search position.
- R9: During and right after reset, `out_req` is low, every queue is empty and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers a write |
| in_addr | input | 32 | Write address; bits above OFFSET pick the queue |
| in_data | input | 32 | Write data word |
| in_ready | output | 1 | Space available in the queue that in_addr maps to |
| out_req | output | 1 | Request presented to the memory controller |
| out_addr | output | 32 | Address of the presented request |
| out_data | output | 32 | Data of the presented request |
| out_ack | input | 1 | Memory controller acknowledge |

## Verification
`in_ready` is combinational on `in_addr`, over queue-full flags registered at the previous edge. It is therefore compared in the same half-cycle in which the bench drives a new address. A write accepted at edge k first becomes eligible for issue at edge k+1, and the issued request is visible after that edge. The bench stamps every modelled entry with its acceptance edge and admits only entries stamped before the current edge when it predicts the next issue. After an acknowledged edge, the bench expects `out_req` low for one cycle, and only then moves the modelled rotation point. Every comparison is made on the falling clock edge, after all registers have settled.

// File: rtl/wq_pkg.sv
package wq_pkg;

    localparam int WQ_ADDR_W = 32;
    localparam int WQ_DATA_W = 32;

    typedef logic [WQ_ADDR_W-1:0] wq_addr_t;
    typedef logic [WQ_DATA_W-1:0] wq_data_t;

    // one buffered write
    typedef struct packed {
        wq_addr_t addr;
        wq_data_t data;
    } wq_req_t;

    // queue number taken from the address slice above the word offset
    function automatic int unsigned queue_of(input wq_addr_t a, input int unsigned shift,
                                             input int unsigned nq);
        return (int'(a >> shift)) % nq;
    endfunction

endpackage

// File: rtl/wq_fifo.sv
module wq_fifo
    import wq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  logic    pop,
    input  wq_req_t wdata,
    output wq_req_t rdata,
    output logic    full,
    output logic    empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    wq_req_t        mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count, count_nxt;
    logic           do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_comb begin
        count_nxt = count;
        if (do_push && !do_pop) count_nxt = count + 1'b1;
        else if (do_pop && !do_push) count_nxt = count - 1'b1;
    end

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count_nxt;
            full  <= (count_nxt == CW'(DEPTH));
            empty <= (count_nxt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/wq_rr_pick.sv
module wq_rr_pick #(
    parameter int NQ = 4
) (
    input  logic [NQ-1:0]         req,
    input  logic [$clog2(NQ)-1:0] base,
    output logic [$clog2(NQ)-1:0] grant,
    output logic                  any
);
    localparam int QW = $clog2(NQ);

    // walk from the highest offset down so the nearest candidate wins last
    always_comb begin
        logic [QW-1:0] idx;
        grant = '0;
        any   = 1'b0;
        for (int i = NQ - 1; i >= 0; i--) begin
            idx = base + QW'(i);
            if (req[idx]) begin
                grant = idx;
                any   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wq_issue.sv
module wq_issue
    import wq_pkg::*;
#(
    parameter int NQ = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  any,
    input  logic [$clog2(NQ)-1:0] grant,
    input  wq_req_t               head,
    input  logic                  ack,
    output logic                  pop,
    output logic [$clog2(NQ)-1:0] rr_ptr,
    output logic                  busy,
    output wq_req_t               held
);
    localparam int QW = $clog2(NQ);

    logic [QW-1:0] served;

    assign pop = !busy && any;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            held   <= '0;
            served <= '0;
            rr_ptr <= '0;
        end else if (busy) begin
            if (ack) begin
                busy   <= 1'b0;
                rr_ptr <= served + 1'b1;
            end
        end else if (any) begin
            busy   <= 1'b1;
            held   <= head;
            served <= grant;
        end
    end

endmodule

// File: rtl/wq_write_channel.sv
module wq_write_channel
    import wq_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int DEPTH  = 4,
    parameter int OFFSET = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WQ_ADDR_W-1:0] in_addr,
    input  logic [WQ_DATA_W-1:0] in_data,
    output logic                 in_ready,
    output logic                 out_req,
    output logic [WQ_ADDR_W-1:0] out_addr,
    output logic [WQ_DATA_W-1:0] out_data,
    input  logic                 out_ack
);
    localparam int QW = $clog2(NQ);

    wq_req_t       in_req;
    wq_req_t       heads [NQ];
    wq_req_t       held;
    logic [QW-1:0] in_q, grant, rr_ptr;
    logic [NQ-1:0] q_push, q_pop, q_full, q_empty;
    logic          any, pop, busy;

    assign in_req.addr = in_addr;
    assign in_req.data = in_data;
    assign in_q        = QW'(queue_of(in_addr, OFFSET, NQ));
    assign in_ready    = !q_full[in_q];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign q_push[g] = in_valid && in_ready && (in_q == QW'(g));
        assign q_pop[g]  = pop && (grant == QW'(g));

        wq_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[g]),
            .pop   (q_pop[g]),
            .wdata (in_req),
            .rdata (heads[g]),
            .full  (q_full[g]),
            .empty (q_empty[g])
        );
    end

    wq_rr_pick #(.NQ(NQ)) u_pick (
        .req   (~q_empty),
        .base  (rr_ptr),
        .grant (grant),
        .any   (any)
    );

    wq_issue #(.NQ(NQ)) u_issue (
        .clk    (clk),
        .rst    (rst),
        .any    (any),
        .grant  (grant),
        .head   (heads[grant]),
        .ack    (out_ack),
        .pop    (pop),
        .rr_ptr (rr_ptr),
        .busy   (busy),
        .held   (held)
    );

    assign out_req  = busy;
    assign out_addr = held.addr;
    assign out_data = held.data;

endmodule

// File: rtl/wq_write_channel_chk.sv
module wq_write_channel_chk
    import wq_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int DEPTH  = 4,
    parameter int OFFSET = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_req,
    input logic [WQ_ADDR_W-1:0] out_addr,
    input logic [WQ_DATA_W-1:0] out_data,
    input logic                 out_ack,
    input logic [NQ-1:0]        q_push,
    input logic [NQ-1:0]        q_full
);
    // R1
    push_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_push));

    // R1
    accept_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (q_push != '0));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (q_push & q_full) == '0);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_req && !out_ack) |=> (out_req && $stable(out_addr) && $stable(out_data)));

    // R7
    drop_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (out_req && out_ack) |=> !out_req);

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!out_req && in_ready));

endmodule

bind wq_write_channel wq_write_channel_chk #(.NQ(NQ), .DEPTH(DEPTH), .OFFSET(OFFSET)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_req  (out_req),
    .out_addr (out_addr),
    .out_data (out_data),
    .out_ack  (out_ack),
    .q_push   (q_push),
    .q_full   (q_full)
);

// File: tb/wq_write_channel_tb.sv
module wq_write_channel_tb;
    localparam int NQ = 4;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_req;
    logic [31:0] out_addr, out_data;
    logic        out_ack = 1'b0;

    wq_write_channel #(.NQ(NQ), .DEPTH(DEPTH), .OFFSET(2)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .in_ready(in_ready), .out_req(out_req), .out_addr(out_addr), .out_data(out_data),
        .out_ack(out_ack)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        int          stamp;
    } ent_t;

    ent_t        mq [NQ][$];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    int          ptr = 0;
    int          served = 0;
    int          issued = 0;
    logic        prev_req = 1'b0;
    logic        prev_ack = 1'b0;
    logic [31:0] hold_a = '0, hold_d = '0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int qof(input logic [31:0] a);
        return int'(a[3:2]);  // R1
    endfunction

    // R4: first queue from ptr holding an entry accepted before edge e
    function automatic int pick(input int e);
        for (int i = 0; i < NQ; i++) begin
            int idx = (ptr + i) % NQ;
            if (mq[idx].size() > 0 && mq[idx][0].stamp < e) return idx;
        end
        return -1;
    endfunction

    // called at a falling edge: compare outputs, then drive the next inputs
    task automatic step(input int vpct, input int apct, input int forceq);
        int p;
        logic [31:0] a;
        if (prev_req) begin
            if (prev_ack) begin
                chk(!out_req, "R7 drop after ack", 64'(out_req), 64'd0);
                ptr = (served + 1) % NQ;
            end else begin
                chk(out_req && out_addr == hold_a && out_data == hold_d, "R6 hold",
                    {out_addr, out_data}, {hold_a, hold_d});
            end
        end else begin
            p = pick(cyc);
            if (p >= 0) begin
                chk(out_req, "R5 issue timing", 64'(out_req), 64'd1);
                chk(out_addr == mq[p][0].addr && out_data == mq[p][0].data,
                    "R3/R4 order", {out_addr, out_data}, {mq[p][0].addr, mq[p][0].data});
                hold_a = mq[p][0].addr;
                hold_d = mq[p][0].data;
                void'(mq[p].pop_front());
                served = p;
                issued++;
            end else begin
                chk(!out_req, "R8 idle stays idle", 64'(out_req), 64'd0);
            end
        end
        prev_req = out_req;
        a = $urandom;
        if (forceq >= 0) a[3:2] = 2'(forceq);
        in_addr  = a;
        in_data  = $urandom;
        in_valid = ($urandom % 100) < vpct;
        out_ack  = ($urandom % 100) < apct;
        prev_ack = out_ack;
        #0.5;
        chk(in_ready == (mq[qof(a)].size() < DEPTH), "R2 ready",
            64'(in_ready), 64'(mq[qof(a)].size() < DEPTH));
        if (in_valid && in_ready) mq[qof(a)].push_back('{a, in_data, cyc + 1});
    endtask

    task automatic run(input int n, input int vpct, input int apct, input int forceq);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step(vpct, apct, forceq);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_req, "R9 reset req", 64'(out_req), 64'd0);
        chk(in_ready, "R9 reset ready", 64'(in_ready), 64'd1);
        rst = 1'b0;
        // R9 / R8: ack pulses while empty must not create a request
        run(6, 0, 100, -1);
        // R2: flood queue 1 with no ack so it fills and ready drops
        run(10, 100, 0, 1);
        // R2: other queue still has room while queue 1 is full
        run(3, 100, 0, 2);
        // R4: drain with ack held high, then mixed traffic
        run(20, 0, 100, -1);
        // R4: all four queues loaded, slow acks
        run(12, 100, 0, -1);
        run(40, 30, 50, -1);
        // R3: single queue stream in order
        run(60, 70, 60, 3);
        // random mix
        run(4000, 60, 45, -1);
        run(2000, 90, 20, -1);
        run(60, 0, 100, -1);
        chk(issued > 100, "R5 traffic flowed", 64'(issued), 64'd100);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule